// File: doc/BRIEF.md
# Weighted Round-Robin Channel Scheduler

This block decides which of several requesters (virtual channels or masters) may drive one shared physical output channel. Each requester carries a 4-bit weight that sets its word budget per round. A granted requester keeps the grant until it has moved that many words, one per cycle in which the transfer strobe is high. The grant then passes to the next eligible requester in rising index order, wrapping from the highest index back to index 0. Over a full round each busy requester therefore receives a share of the channel in proportion to its weight. The worst-case wait for a requester that has just become busy is one round, which is the sum of all weights.

Requesters that are idle or have a weight of zero are passed over in the same cycle, so no slot is lost on them. A requester that withdraws before its budget is spent loses the rest of that budget for the current round. A one-cycle pulse marks each return of the scheduling position to the low end of the index range. The data multiplexer and the buffers that feed it sit outside this block and use the grant vector to steer words.

Top module: `wrr_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, the scheduling position is index 0 and `round_done_o` is 0. In that first cycle the grant goes to the lowest-index eligible requester.
- R2: A requester is granted only while its `req_i` bit is high and its weight field (bits `[4*i+3:4*i]` of `weight_i`) is non-zero. A weight of 0 keeps the requester out of scheduling.
- R3: `grant_o` is one-hot, or all zero exactly when no requester is eligible.
- R4: A requester that holds the grant and sees `xfer_i` high for a number of cycles equal to its weight gives up the grant after the last of those cycles. The grant goes to the next eligible requester with a higher index, or wraps to the lowest eligible index.
- R5: The grant search starts at the current scheduling position, passes over non-eligible requesters combinationally in the same cycle, and wraps to index 0 when nothing at or above the position is eligible.
- R6: If the granted requester drops `req_i` before its budget is spent, the grant moves on in that same cycle and the unused budget is forfeited. Raising the request again in the same round does not bring the grant back until the position wraps.
- R7: `round_done_o` is high for one cycle, in the cycle after either of two events: the budget of the highest-index requester is used up, or the grant wraps to an index below the current position.
- R8: With every requester busy and `xfer_i` high every cycle, each requester holds the grant for exactly its weight in cycles within each round of sum-of-weights cycles.
- R9: `xfer_i` high while no grant is issued changes no scheduling state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_REQ | Per-requester request lines |
| weight_i | input | N_REQ*W_BITS | Packed weights; requester i uses bits [W_BITS*i +: W_BITS] |
| xfer_i | input | 1 | One word moved on the channel this cycle |
| grant_o | output | N_REQ | One-hot grant, or zero when nobody is eligible |
| round_done_o | output | 1 | One-cycle pulse after the scheduling position wraps |

## Verification
The bench builds the scheduler with its defaults of four requesters and 4-bit weights. With these values a full round is at most 60 cycles, so thousands of random cycles cover many wraps, weight-zero exclusions and forfeits. Four requesters are enough for the search to wrap past several idle indices at once. Directed phases cover the proportional split with weights 1 to 4, withdrawal in mid-budget, and strobes that arrive while no grant is issued.

// File: rtl/wrr_pkg.sv
`timescale 1ns/1ps
package wrr_pkg;
    // Index type wide enough for up to 256 requesters.
    localparam int IDX_BITS = 8;
    typedef logic [IDX_BITS-1:0] idx_t;

    // Result of the rotating search.
    typedef struct packed {
        logic found;    // some requester is eligible
        logic wrapped;  // chosen index lies below the search base
        idx_t sel;      // chosen index
    } pick_t;

    function automatic idx_t next_index(input idx_t cur, input int unsigned n);
        if (cur == idx_t'(n - 1)) return '0;
        return cur + idx_t'(1);
    endfunction
endpackage

// File: rtl/wrr_pick.sv
`timescale 1ns/1ps
module wrr_pick
    import wrr_pkg::*;
#(
    parameter int N_REQ = 4
) (
    input  logic [N_REQ-1:0] elig,
    input  idx_t             base,
    output pick_t            res
);
    idx_t hi_idx, lo_idx;
    logic hi_ok, lo_ok;

    // Descending scan leaves the lowest match in each class.
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        hi_ok  = 1'b0;
        lo_ok  = 1'b0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                lo_idx = idx_t'(i);
                lo_ok  = 1'b1;
                if (idx_t'(i) >= base) begin
                    hi_idx = idx_t'(i);
                    hi_ok  = 1'b1;
                end
            end
        end
    end

    always_comb begin
        res = '0;
        if (hi_ok) begin
            res.found   = 1'b1;
            res.sel     = hi_idx;
        end else if (lo_ok) begin
            res.found   = 1'b1;
            res.wrapped = 1'b1;
            res.sel     = lo_idx;
        end
    end
endmodule

// File: rtl/wrr_budget.sv
`timescale 1ns/1ps
module wrr_budget
    import wrr_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int W_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  pick_t             res,
    input  logic [W_BITS-1:0] w_sel,
    input  logic              xfer,
    output idx_t              pos,
    output logic              wrap_pulse
);
    localparam idx_t LAST = idx_t'(N_REQ - 1);

    idx_t              pos_q;
    logic [W_BITS-1:0] used_q;
    logic              pulse_q;

    logic [W_BITS-1:0] used_eff;
    logic [W_BITS:0]   used_inc;
    logic              spent;
    logic              at_last;

    // A different holder than the stored position starts from zero.
    assign used_eff = (res.sel == pos_q) ? used_q : '0;
    assign used_inc = {1'b0, used_eff} + {{W_BITS{1'b0}}, 1'b1};
    assign spent    = res.found && xfer && (used_inc >= {1'b0, w_sel});
    assign at_last  = (res.sel == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            used_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (res.found) begin
                pulse_q <= res.wrapped | (spent & at_last);
                if (spent) begin
                    pos_q  <= next_index(res.sel, N_REQ);
                    used_q <= '0;
                end else if (xfer) begin
                    pos_q  <= res.sel;
                    used_q <= used_inc[W_BITS-1:0];
                end else begin
                    pos_q  <= res.sel;
                    used_q <= used_eff;
                end
            end
        end
    end

    assign pos        = pos_q;
    assign wrap_pulse = pulse_q;

    // R7: a pulse always leaves the position at or after a wrap, never mid-round above start with a stale pulse
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse || $past(res.found));

    // R9: a strobe with nothing granted leaves the state untouched
    a_r9_idle_strobe: assert property (@(posedge clk) disable iff (rst)
        (!res.found && xfer) |=> $stable(pos_q) && $stable(used_q));
endmodule

// File: rtl/wrr_sched.sv
`timescale 1ns/1ps
module wrr_sched
    import wrr_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int W_BITS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ-1:0]        req_i,
    input  logic [N_REQ*W_BITS-1:0] weight_i,
    input  logic                    xfer_i,
    output logic [N_REQ-1:0]        grant_o,
    output logic                    round_done_o
);
    localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic [W_BITS-1:0] w_arr [N_REQ];
    logic [N_REQ-1:0]  elig;
    logic [N_REQ-1:0]  zero_w;
    pick_t             res;
    idx_t              pos;
    logic [W_BITS-1:0] w_sel;

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        assign w_arr[g]   = weight_i[g*W_BITS +: W_BITS];
        assign zero_w[g]  = (w_arr[g] == '0);
        assign elig[g]    = req_i[g] & ~zero_w[g];
        assign grant_o[g] = res.found && (res.sel == idx_t'(g));
    end

    assign w_sel = w_arr[res.sel[SEL_W-1:0]];

    wrr_pick #(.N_REQ(N_REQ)) u_pick (
        .elig (elig),
        .base (pos),
        .res  (res)
    );

    wrr_budget #(.N_REQ(N_REQ), .W_BITS(W_BITS)) u_budget (
        .clk        (clk),
        .rst        (rst),
        .res        (res),
        .w_sel      (w_sel),
        .xfer       (xfer_i),
        .pos        (pos),
        .wrap_pulse (round_done_o)
    );

    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    a_r2_needs_request: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~req_i) == '0);

    a_r2_zero_weight_out: assert property (@(posedge clk) disable iff (rst)
        (grant_o & zero_w) == '0);

    a_r5_no_idle_slot: assert property (@(posedge clk) disable iff (rst)
        (req_i & ~zero_w) != '0 |-> grant_o != '0);
endmodule

// File: tb/test_wrr_sched.sv
`timescale 1ns/1ps
module test_wrr_sched;
    localparam int N = 4;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   req = '0;
    logic [N*W-1:0] wts = '0;
    logic           xfer = 1'b0;
    logic [N-1:0]   grant;
    logic           round_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    int m_pos = 0;
    int m_used = 0;
    bit m_rd = 0;
    bit counting = 0;
    int gcount [N];

    always #10 clk = ~clk;

    wrr_sched #(.N_REQ(N), .W_BITS(W)) i_wrr_sched (
        .clk(clk), .rst(rst), .req_i(req), .weight_i(wts),
        .xfer_i(xfer), .grant_o(grant), .round_done_o(round_done)
    );

    function automatic int wgt(input int i);
        return int'(wts[i*W +: W]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_pick(output bit f, output int s, output bit wr);
        f = 0; s = 0; wr = 0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (m_pos + k) % N;
            if (req[idx] && wgt(idx) != 0) begin
                f = 1; s = idx; wr = (idx < m_pos);
                break;
            end
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic x, input string tag);
        bit f, wr;
        int s, eff;
        logic [N-1:0] eg;
        req = r; xfer = x;
        #5;
        m_pick(f, s, wr);
        eg = f ? (N'(1) << s) : '0;
        chk(grant === eg, tag, int'(grant), int'(eg));
        chk(round_done === m_rd, "R7", int'(round_done), int'(m_rd));
        if (counting) for (int i = 0; i < N; i++) gcount[i] += int'(grant[i]);
        @(posedge clk);
        m_rd = 0;
        if (f) begin
            eff = (s == m_pos) ? m_used : 0;
            if (x && eff + 1 >= wgt(s)) begin
                m_rd = wr || (s == N - 1);
                m_pos = (s == N - 1) ? 0 : s + 1;
                m_used = 0;
            end else begin
                m_rd = wr;
                m_pos = s;
                m_used = x ? eff + 1 : eff;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; req = '0; xfer = 1'b0;
        @(negedge clk); @(negedge clk);
        #5;
        chk(grant === '0 && round_done === 1'b0, "R1", int'({round_done, grant}), 0);
        @(negedge clk);
        rst = 1'b0;
        m_pos = 0; m_used = 0; m_rd = 0;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state, then first grant goes to lowest eligible
        wts = {4'd2, 4'd2, 4'd2, 4'd2};
        do_reset();
        step(4'b1010, 1'b0, "R1");

        // R8: proportional split, weights 1..4, everyone busy
        wts = {4'd4, 4'd3, 4'd2, 4'd1};
        do_reset();
        for (int i = 0; i < N; i++) gcount[i] = 0;
        counting = 1;
        for (int c = 0; c < 20; c++) step(4'b1111, 1'b1, "R4");
        counting = 0;
        for (int i = 0; i < N; i++) chk(gcount[i] == 2 * wgt(i), "R8", gcount[i], 2 * wgt(i));
        step(4'b1111, 1'b1, "R4");

        // R2: zero weight excluded even when requesting
        wts = {4'd3, 4'd0, 4'd2, 4'd0};
        do_reset();
        for (int c = 0; c < 12; c++) step(4'b1111, 1'b1, "R2");

        // R6: withdrawal mid-budget forfeits the rest of it
        wts = {4'd3, 4'd3, 4'd3, 4'd3};
        do_reset();
        step(4'b0011, 1'b1, "R6");
        step(4'b0010, 1'b0, "R6");   // holder 0 drops, grant to 1 at once
        step(4'b0011, 1'b1, "R6");   // 0 returns, stays with 1
        step(4'b0011, 1'b1, "R6");
        step(4'b0011, 1'b1, "R6");   // 1 spends its 3rd word
        step(4'b0011, 1'b0, "R6");   // wrap back to 0

        // R5: skip idle requesters, wrap over a gap
        step(4'b1000, 1'b0, "R5");
        step(4'b0100, 1'b1, "R5");
        step(4'b0001, 1'b0, "R5");

        // R9: strobes with nobody granted
        for (int c = 0; c < 5; c++) step(4'b0000, 1'b1, "R9");
        step(4'b0001, 1'b1, "R9");
        step(4'b0001, 1'b1, "R9");

        // R3/R4: constrained random traffic with weight changes
        void'($urandom(32'd20240611));
        for (int blk = 0; blk < 20; blk++) begin
            for (int i = 0; i < N; i++)
                wts[i*W +: W] = ($urandom % 6 == 0) ? 4'd0 : W'($urandom % 16);
            for (int c = 0; c < 200; c++) begin
                logic [N-1:0] rr;
                rr = N'($urandom);
                if ($urandom % 4 != 0) rr = rr | grant;   // holders tend to stay busy
                step(rr, 1'($urandom % 4 != 0), "R3");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule